// File: doc/BRIEF.md
# Clock Frequency Window Monitor

This block supervises a fast system clock against a slow, trusted reference tick, such as one derived from a 32.768 kHz crystal that is assumed accurate. The reference input comes in asynchronously. It passes through a synchronizer inside the block, and each rising edge becomes one reference event. Between two events the block counts system-clock cycles. At each event it checks that the count lies strictly inside a programmable window, and then it restarts the count.

A second counter acts as a watchdog on the reference itself. If too many system cycles pass without a reference event, the block raises a reference-loss flag. Both error flags are sticky. A clear strobe resets the flags, both counters and the arming state. After a clear, the first event only starts a measurement.

The monitor gives no useful result when the system clock is itself derived from the reference oscillator. Software programs the window bounds and the loss limit and holds them stable while the monitor runs.

Top module: `clk_rate_guard`

## Requirements
- R1: After reset, `freq_err` and `ref_lost` are 0.
- R2: Each rising edge of `ref_in` produces exactly one reference event, however many cycles `ref_in` stays high.
- R3: When the rising edges of `ref_in` are P system cycles apart, the value compared at the later event is P-1.
- R4: At an armed reference event, `freq_err` becomes 1 when the compared count is less than or equal to `lo_bound`, or greater than or equal to `hi_bound`. A count strictly between the bounds leaves `freq_err` unchanged.
- R5: The first reference event after reset or after a clear only arms the measurement and never sets `freq_err`.
- R6: The cycle count saturates at 2^CNT_W-1 instead of wrapping. A long interval therefore compares as the maximum value.
- R7: `ref_lost` becomes 1 when more than `loss_limit` system cycles pass without a reference event, counting from the last event, reset or clear. With `loss_limit` = L it sets on the L-th cycle edge after a clear. Reference events spaced exactly L cycles apart never set it.
- R8: Both flags stay set until `clr_flags` is sampled high. The cycle after the clear strobe, both flags read 0, and counting and arming restart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Monitored system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_in | input | 1 | Asynchronous reference tick from the trusted slow oscillator |
| lo_bound | input | CNT_W | Count must be strictly greater than this value |
| hi_bound | input | CNT_W | Count must be strictly less than this value |
| loss_limit | input | WD_W | Longest allowed number of cycles without a reference event |
| clr_flags | input | 1 | Strobe that clears both flags, both counters and the arming state |
| freq_err | output | 1 | Sticky out-of-window frequency flag |
| ref_lost | output | 1 | Sticky reference-loss flag |

## Verification
On every cycle, the assertions check the following: that both flags hold while no clear is given, that the clear strobe empties both flags, and that `freq_err` rises only after an armed reference event. They also check that a reference event restarts the count, that a saturated count never wraps, and that the watchdog restarts on each event. The exact count value compared at an event, and the strictness of both window edges, show only through the bench's timed pulse trains. The same holds for the arming rule, the long-high reference input and the exact cycle at which `ref_lost` rises, because each depends on the spacing of the stimulus.

// File: rtl/clk_rate_guard.sv
module clk_rate_guard #(
  parameter int CNT_W = 16,
  parameter int WD_W  = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_in,
  input  logic [CNT_W-1:0] lo_bound,
  input  logic [CNT_W-1:0] hi_bound,
  input  logic [WD_W-1:0]  loss_limit,
  input  logic             clr_flags,
  output logic             freq_err,
  output logic             ref_lost
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [WD_W-1:0]  WD_MAX  = {WD_W{1'b1}};

  logic [2:0]       sync_q;
  logic             ref_evt;
  logic [CNT_W-1:0] cnt_q;
  logic [WD_W-1:0]  wd_q;
  logic             armed_q;
  logic             in_win;
  logic             late;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], ref_in};

  assign ref_evt = sync_q[1] & ~sync_q[2];
  assign in_win  = (cnt_q > lo_bound) && (cnt_q < hi_bound);
  assign late    = ({1'b0, wd_q} + 1'b1) >= {1'b0, loss_limit};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                       cnt_q <= '0;
    else if (clr_flags || ref_evt)    cnt_q <= '0;
    else if (cnt_q != CNT_MAX)        cnt_q <= cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                       wd_q <= '0;
    else if (clr_flags || ref_evt)    wd_q <= '0;
    else if (wd_q != WD_MAX)          wd_q <= wd_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         armed_q <= 1'b0;
    else if (clr_flags) armed_q <= 1'b0;
    else if (ref_evt)   armed_q <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                               freq_err <= 1'b0;
    else if (clr_flags)                       freq_err <= 1'b0;
    else if (ref_evt && armed_q && !in_win)   freq_err <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                  ref_lost <= 1'b0;
    else if (clr_flags)          ref_lost <= 1'b0;
    else if (!ref_evt && late)   ref_lost <= 1'b1;
endmodule

// File: rtl/clk_rate_guard_chk.sv
module clk_rate_guard_chk #(
  parameter int CNT_W = 16,
  parameter int WD_W  = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr_flags,
  input logic             ref_evt,
  input logic             armed_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [WD_W-1:0]  wd_q,
  input logic             freq_err,
  input logic             ref_lost
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  AST_FREQ_STICKY:  assert property (@(posedge clk) disable iff (!rst_n) freq_err && !clr_flags |=> freq_err); // R8
  AST_LOST_STICKY:  assert property (@(posedge clk) disable iff (!rst_n) ref_lost && !clr_flags |=> ref_lost); // R8
  AST_CLEAR_EMPTY:  assert property (@(posedge clk) disable iff (!rst_n) clr_flags |=> !freq_err && !ref_lost); // R8
  AST_ERR_AT_EVENT: assert property (@(posedge clk) disable iff (!rst_n) $rose(freq_err) |-> $past(ref_evt && armed_q)); // R5
  AST_EVT_RESTART:  assert property (@(posedge clk) disable iff (!rst_n) ref_evt |=> cnt_q == '0 && wd_q == '0); // R3
  AST_NO_WRAP:      assert property (@(posedge clk) disable iff (!rst_n) cnt_q == CNT_MAX && !clr_flags && !ref_evt |=> cnt_q == CNT_MAX); // R6
endmodule

bind clk_rate_guard clk_rate_guard_chk #(.CNT_W(CNT_W), .WD_W(WD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_flags(clr_flags), .ref_evt(ref_evt),
  .armed_q(armed_q), .cnt_q(cnt_q), .wd_q(wd_q),
  .freq_err(freq_err), .ref_lost(ref_lost)
);

// File: tb/clk_rate_guard_bench.sv
module clk_rate_guard_bench;
  localparam int CNT_W = 8;
  localparam int WD_W  = 12;
  localparam int NV    = 8;
  localparam int V_LO  [NV] = '{10, 10, 10, 10, 10, 10, 30, 30};
  localparam int V_HI  [NV] = '{20, 20, 20, 20, 20, 20, 255, 255};
  localparam int V_P   [NV] = '{16, 11, 12, 21, 20, 5, 300, 200};
  localparam int V_ERR [NV] = '{0, 1, 0, 1, 0, 1, 1, 0};

  logic clk = 0, rst_n = 0, ref_in = 0, clr_flags = 0;
  logic [CNT_W-1:0] lo_bound = '0, hi_bound = '0;
  logic [WD_W-1:0]  loss_limit = '0;
  logic freq_err, ref_lost;
  int vectors = 0, miscompares = 0;

  always #2 clk = ~clk;

  clk_rate_guard #(.CNT_W(CNT_W), .WD_W(WD_W)) u_clk_rate_guard (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .lo_bound(lo_bound),
    .hi_bound(hi_bound), .loss_limit(loss_limit), .clr_flags(clr_flags),
    .freq_err(freq_err), .ref_lost(ref_lost)
  );

  task automatic chk(input string tag, input logic got, input logic exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic clear();
    @(negedge clk) clr_flags = 1;
    @(negedge clk) clr_flags = 0;
  endtask

  task automatic train(input int n, input int p);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) ref_in = 1;
      @(negedge clk) ref_in = 0;
      repeat (p - 2) @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 freq_err after reset", freq_err, 0);
    chk("R1 ref_lost after reset", ref_lost, 0);
    rst_n = 1;
    loss_limit = 4000;

    for (int i = 0; i < NV; i++) begin
      lo_bound = V_LO[i][CNT_W-1:0];
      hi_bound = V_HI[i][CNT_W-1:0];
      clear();
      train(3, V_P[i]);
      chk($sformatf("R3/R4/R6 vector %0d", i), freq_err, V_ERR[i][0]);
    end

    // R8: sticky through good intervals, cleared by strobe
    lo_bound = 10; hi_bound = 20;
    clear(); train(3, 11);
    chk("R4 low edge error", freq_err, 1);
    train(3, 15);
    chk("R8 freq_err sticky", freq_err, 1);
    clear();
    chk("R8 freq_err cleared", freq_err, 0);

    // R5: first event after clear only arms (count ~7 is below the window)
    clear();
    repeat (5) @(negedge clk);
    train(1, 16);
    chk("R5 arming event ignored", freq_err, 0);
    train(2, 16);
    chk("R5 measurement after arming", freq_err, 0);

    // R2: long-high reference gives one event per rising edge
    clear();
    for (int k = 0; k < 3; k++) begin
      @(negedge clk) ref_in = 1;
      repeat (10) @(negedge clk);
      ref_in = 0;
      repeat (6) @(negedge clk);
    end
    chk("R2 long-high single event", freq_err, 0);

    // R7: loss watchdog
    lo_bound = 0; hi_bound = 255; loss_limit = 20;
    clear();
    train(4, 20);
    chk("R7 gap equal to limit", ref_lost, 0);
    train(1, 21);
    train(1, 21);
    chk("R7 gap above limit", ref_lost, 1);
    train(1, 20);
    chk("R8 ref_lost sticky", ref_lost, 1);
    clear();
    chk("R8 ref_lost cleared", ref_lost, 0);
    repeat (19) @(negedge clk);
    chk("R7 no loss one cycle early", ref_lost, 0);
    repeat (2) @(negedge clk);
    chk("R7 loss after silence", ref_lost, 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule